// File: doc/BRIEF.md
# Transmit Buffer Request Arbiter

This block tracks transmit requests for a small set of dedicated transmit buffers in a CAN controller. Software raises requests and cancellations through two write-one-to-set bit vectors (bit i addresses buffer i). For each buffer the block holds a request-pending bit. It also holds a cancellation-request bit, a transmission-occurred bit and a cancellation-finished bit.

Whenever the set of pending buffers changes, a sequential priority scan runs. It visits one buffer per clock, in ascending index order, and selects the pending buffer with the numerically lowest message ID. That buffer is then offered to the protocol engine. The engine reports four kinds of event, each tagged with a buffer index: frame start, success, arbitration loss and frame error. The block turns these events into the per-buffer result bits. One interrupt line combines the result bits with per-buffer enables.

Cancelling a buffer whose frame is already on the bus takes effect only when that frame ends. A no-retransmit mode turns every failed attempt into a finished cancellation.

Top module: `can_txreq_mgr`

## Requirements
- R1: An add write sets the pending bit of each buffer whose data bit is 1. Zero bits leave the other buffers unchanged. Several buffers can be requested in one write.
- R2: When no scan is running, add bits take effect at once and `add_pend` stays 0. An add write that arrives while a scan runs is held in `add_pend` and merged into the pending bits when the scan ends.
- R3: Each scan takes NBUF cycles. At its end `sel_valid` shows whether any buffer is pending. `sel_idx` is the pending buffer with the lowest `msg_id`. When IDs are equal, the lower index wins. Buffer i's ID is `msg_id[i*IDW +: IDW]`.
- R4: A cancel write sets `cxl_req[i]` only for a buffer that is pending. The bit stays set until pending bit i clears, and it clears one cycle after that.
- R5: A cancellation of a pending buffer that is not in flight clears its pending bit and sets `cxl_done[i]`. A cancel write to a buffer that is not pending sets `cxl_done[i]` on the next edge.
- R6: While buffer i is in flight (after `eng_start` with index i, and before its ending event), a cancellation does not clear its pending bit.
- R7: `eng_ok` for buffer i clears its pending bit and sets `tx_done[i]`. If a cancellation was requested for it, `cxl_done[i]` is set as well.
- R8: `eng_lost` or `eng_err` for a buffer with a cancellation requested clears its pending bit and sets `cxl_done[i]`. `tx_done[i]` stays 0.
- R9: With `no_retx` high, `eng_lost` or `eng_err` clears the pending bit and sets `cxl_done[i]`.
- R10: With `no_retx` low and no cancellation, `eng_lost` or `eng_err` leaves the buffer pending and starts a new scan. The new scan selects the buffer again.
- R11: An add write with bit i set clears `tx_done[i]` and `cxl_done[i]`.
- R12: `irq` is the OR over all buffers of (`tx_done` AND `tie_en`) and (`cxl_done` AND `cie_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| add_we | input | 1 | Add-request write strobe |
| add_data | input | NBUF | Add bits, write-one-to-set |
| cxl_we | input | 1 | Cancel-request write strobe |
| cxl_data | input | NBUF | Cancel bits, write-one-to-set |
| no_retx | input | 1 | Disable automatic retransmission |
| msg_id | input | NBUF*IDW | Message ID per buffer |
| eng_start | input | 1 | Engine began sending `eng_idx` |
| eng_ok | input | 1 | Frame of `eng_idx` succeeded |
| eng_lost | input | 1 | Frame of `eng_idx` lost arbitration |
| eng_err | input | 1 | Frame of `eng_idx` hit an error |
| eng_idx | input | IW | Buffer index of the engine event |
| tie_en | input | NBUF | Transmission-occurred interrupt enables |
| cie_en | input | NBUF | Cancellation-finished interrupt enables |
| pend | output | NBUF | Request-pending bits |
| add_pend | output | NBUF | Add requests held during a scan |
| cxl_req | output | NBUF | Cancellation-request bits |
| tx_done | output | NBUF | Transmission-occurred bits |
| cxl_done | output | NBUF | Cancellation-finished bits |
| scan_busy | output | 1 | Priority scan in progress |
| sel_valid | output | 1 | A selection is available |
| sel_idx | output | IW | Selected buffer |
| irq | output | 1 | Interrupt |

## Verification
The bench sweeps every subset of pending buffers against ID sets that contain ties. A scan that compares with the wrong sense, or that lets the higher index win a tie, picks the wrong buffer. An add written in the middle of a scan checks the hold path: a design without it would either drop the request or change the pending set while the scan is still reading it. Cancellation is tested in flight, on an idle pending buffer and on an empty buffer, each followed by success, loss or error. A design that clears the in-flight buffer early, forgets to set the finished bit, or retries in no-retransmit mode fails those checks.

// File: rtl/can_txreq_mgr.sv
module can_txreq_mgr #(
  parameter int NBUF = 3,
  parameter int IDW  = 11,
  localparam int IW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_we,
  input  logic [NBUF-1:0]   add_data,
  input  logic              cxl_we,
  input  logic [NBUF-1:0]   cxl_data,
  input  logic              no_retx,
  input  logic [NBUF*IDW-1:0] msg_id,
  input  logic              eng_start,
  input  logic              eng_ok,
  input  logic              eng_lost,
  input  logic              eng_err,
  input  logic [IW-1:0]     eng_idx,
  input  logic [NBUF-1:0]   tie_en,
  input  logic [NBUF-1:0]   cie_en,
  output logic [NBUF-1:0]   pend,
  output logic [NBUF-1:0]   add_pend,
  output logic [NBUF-1:0]   cxl_req,
  output logic [NBUF-1:0]   tx_done,
  output logic [NBUF-1:0]   cxl_done,
  output logic              scan_busy,
  output logic              sel_valid,
  output logic [IW-1:0]     sel_idx,
  output logic              irq
);

  logic [NBUF-1:0] add_set, cxl_set, add_now, pend_n, done_n, cd_n;
  logic [IW-1:0]   ptr, best_idx, tx_idx;
  logic [IDW-1:0]  best_id, cur_id;
  logic            found, dirty, tx_on, fail_keep, scan_last, cand, chg;

  assign add_set   = add_we ? add_data : '0;
  assign cxl_set   = cxl_we ? cxl_data : '0;
  assign scan_last = scan_busy && (ptr == IW'(NBUF-1));
  assign add_now   = (scan_busy && !scan_last) ? '0 : (add_set | add_pend);
  assign cur_id    = msg_id[int'(ptr)*IDW +: IDW];
  assign cand      = pend[ptr] && (!found || cur_id < best_id);
  assign chg       = (pend_n != pend) || fail_keep;
  assign irq       = |((tx_done & tie_en) | (cxl_done & cie_en));

  always_comb begin
    pend_n    = pend;
    done_n    = tx_done;
    cd_n      = cxl_done;
    fail_keep = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      if (eng_ok && eng_idx == IW'(i)) begin
        pend_n[i] = 1'b0;
        done_n[i] = 1'b1;
        if (cxl_req[i] || cxl_set[i]) cd_n[i] = 1'b1;
      end else if ((eng_lost || eng_err) && eng_idx == IW'(i)) begin
        if (cxl_req[i] || cxl_set[i] || no_retx) begin
          pend_n[i] = 1'b0;
          cd_n[i]   = 1'b1;
        end else begin
          fail_keep = 1'b1;
        end
      end else if (cxl_req[i] && pend[i] && !(tx_on && tx_idx == IW'(i))) begin
        pend_n[i] = 1'b0;
        cd_n[i]   = 1'b1;
      end else if (cxl_set[i] && !pend[i]) begin
        cd_n[i] = 1'b1;
      end
      if (add_set[i]) begin
        done_n[i] = 1'b0;
        cd_n[i]   = 1'b0;
      end
      if (add_now[i]) pend_n[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= '0;
      add_pend  <= '0;
      cxl_req   <= '0;
      tx_done   <= '0;
      cxl_done  <= '0;
      tx_on     <= 1'b0;
      tx_idx    <= '0;
      dirty     <= 1'b0;
      scan_busy <= 1'b0;
      ptr       <= '0;
      found     <= 1'b0;
      best_idx  <= '0;
      best_id   <= '0;
      sel_valid <= 1'b0;
      sel_idx   <= '0;
    end else begin
      pend     <= pend_n;
      tx_done  <= done_n;
      cxl_done <= cd_n;
      cxl_req  <= (cxl_req | cxl_set) & pend;
      add_pend <= (scan_busy && !scan_last) ? (add_pend | add_set) : '0;
      dirty    <= chg || (dirty && scan_busy);

      if (eng_ok || eng_lost || eng_err) tx_on <= 1'b0;
      else if (eng_start) begin
        tx_on  <= 1'b1;
        tx_idx <= eng_idx;
      end

      if (!scan_busy) begin
        if (dirty) begin
          scan_busy <= 1'b1;
          ptr       <= '0;
          found     <= 1'b0;
          sel_valid <= 1'b0;
        end
      end else begin
        if (cand) begin
          best_idx <= ptr;
          best_id  <= cur_id;
          found    <= 1'b1;
        end
        if (scan_last) begin
          scan_busy <= 1'b0;
          sel_valid <= found || cand;
          sel_idx   <= cand ? ptr : best_idx;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end

  p_add_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (add_pend != '0) |-> scan_busy);

  p_cxl_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cxl_req & ~pend) != '0) |=> ((cxl_req & $past(cxl_req & ~pend)) == '0));

  p_defer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_on && pend[tx_idx] && !eng_ok && !eng_lost && !eng_err) |=> pend[$past(tx_idx)]);

  p_done_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_ok && !add_we && eng_idx < IW'(NBUF)) |=> tx_done[$past(eng_idx)]);

  p_no_retx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (no_retx && (eng_lost || eng_err) && !add_we && add_pend == '0 && eng_idx < IW'(NBUF))
    |=> (!pend[$past(eng_idx)] && cxl_done[$past(eng_idx)]));

endmodule

// File: tb/can_txreq_mgr_tb_top.sv
module can_txreq_mgr_tb_top;
  localparam int NBUF = 3;
  localparam int IDW  = 11;
  localparam int IW   = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic add_we = 0, cxl_we = 0, no_retx = 0;
  logic [NBUF-1:0] add_data = 0, cxl_data = 0, tie_en = 0, cie_en = 0;
  logic [NBUF*IDW-1:0] msg_id = 0;
  logic eng_start = 0, eng_ok = 0, eng_lost = 0, eng_err = 0;
  logic [IW-1:0] eng_idx = 0;
  logic [NBUF-1:0] pend, add_pend, cxl_req, tx_done, cxl_done;
  logic scan_busy, sel_valid, irq;
  logic [IW-1:0] sel_idx;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  can_txreq_mgr #(.NBUF(NBUF), .IDW(IDW)) dut_i (
    .clk(clk), .rst_n(rst_n), .add_we(add_we), .add_data(add_data),
    .cxl_we(cxl_we), .cxl_data(cxl_data), .no_retx(no_retx), .msg_id(msg_id),
    .eng_start(eng_start), .eng_ok(eng_ok), .eng_lost(eng_lost), .eng_err(eng_err),
    .eng_idx(eng_idx), .tie_en(tie_en), .cie_en(cie_en), .pend(pend),
    .add_pend(add_pend), .cxl_req(cxl_req), .tx_done(tx_done), .cxl_done(cxl_done),
    .scan_busy(scan_busy), .sel_valid(sel_valid), .sel_idx(sel_idx), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_add(logic [NBUF-1:0] m);
    add_we = 1; add_data = m;
    @(negedge clk);
    add_we = 0; add_data = 0;
  endtask

  task automatic wr_cxl(logic [NBUF-1:0] m);
    cxl_we = 1; cxl_data = m;
    @(negedge clk);
    cxl_we = 0; cxl_data = 0;
  endtask

  task automatic eng(int kind, int idx);
    eng_idx = IW'(idx);
    case (kind)
      0: eng_start = 1;
      1: eng_ok = 1;
      2: eng_lost = 1;
      default: eng_err = 1;
    endcase
    @(negedge clk);
    eng_start = 0; eng_ok = 0; eng_lost = 0; eng_err = 0;
  endtask

  task automatic set_ids(int a, int b, int c);
    msg_id = {IDW'(c), IDW'(b), IDW'(a)};
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vals[3] = '{3, 7, 12};
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    check("reset pend", 32'(pend), 0);
    check("reset sel_valid", 32'(sel_valid), 0);
    check("reset irq", 32'(irq), 0);

    // R3 sweep over ID triples with ties and all pending subsets
    for (int p = 0; p < 27; p++) begin
      int ida, idb, idc;
      ida = vals[p % 3]; idb = vals[(p / 3) % 3]; idc = vals[p / 9];
      set_ids(ida, idb, idc);
      for (int m = 1; m < 8; m++) begin
        int best, bid;
        int ids[3];
        ids = '{ida, idb, idc};
        wr_cxl(3'b111);
        wait_n(8);
        best = -1; bid = 0;
        for (int i = 0; i < 3; i++)
          if (m[i] && (best < 0 || ids[i] < bid)) begin best = i; bid = ids[i]; end
        wr_add(3'(m));
        wait_n(10);
        check("R1 pend after add", 32'(pend), 32'(m));
        check("R3 sel_valid", 32'(sel_valid), 1);
        check("R3 sel_idx", 32'(sel_idx), 32'(best));
      end
    end
    wr_cxl(3'b111);
    wait_n(10);
    check("R3 none pending", 32'(sel_valid), 0);

    // R1 zero bits leave others; R2 idle add clears at once
    set_ids(20, 10, 30);
    wr_add(3'b001);
    check("R2 idle add not held", 32'(add_pend), 0);
    wait_n(10);
    wr_add(3'b100);
    wait_n(10);
    check("R1 zero bits no effect", 32'(pend), 32'b101);
    // R2 add during scan is held
    wr_add(3'b010);
    @(negedge clk);
    check("R2 scan running", 32'(scan_busy), 1);
    check("R2 scan running pend", 32'(pend), 32'b111);
    wr_cxl(3'b111);
    wait_n(10);
    wr_add(3'b001);
    @(negedge clk);
    wr_add(3'b100);
    check("R2 held during scan", 32'(add_pend), 32'b100);
    check("R2 not yet pending", 32'(pend[2]), 0);
    wait_n(12);
    check("R2 merged after scan", 32'(pend), 32'b101);
    check("R2 hold cleared", 32'(add_pend), 0);

    // R7 success and R12 interrupt
    wr_add(3'b010);
    wait_n(12);
    check("R3 pick lowest id", 32'(sel_idx), 1);
    eng(0, 1);
    eng(1, 1);
    check("R7 pend cleared", 32'(pend), 32'b101);
    check("R7 tx_done", 32'(tx_done), 32'b010);
    check("R7 no cancel finish", 32'(cxl_done), 0);
    tie_en = 3'b010; #1;
    check("R12 irq enabled", 32'(irq), 1);
    tie_en = 3'b101; #1;
    check("R12 irq masked", 32'(irq), 0);
    tie_en = 0;
    wait_n(10);

    // R6 deferred cancel, ends with success
    eng(0, 0);
    wr_cxl(3'b001);
    wait_n(3);
    check("R6 still pending", 32'(pend[0]), 1);
    check("R4 cxl_req held", 32'(cxl_req[0]), 1);
    eng(1, 0);
    check("R7 pend0 cleared", 32'(pend[0]), 0);
    check("R7 tx_done0", 32'(tx_done[0]), 1);
    check("R7 cxl_done0 with cancel", 32'(cxl_done[0]), 1);
    check("R4 cxl_req one more cycle", 32'(cxl_req[0]), 1);
    @(negedge clk);
    check("R4 cxl_req cleared", 32'(cxl_req[0]), 0);
    cie_en = 3'b001; #1;
    check("R12 cancel irq", 32'(irq), 1);
    cie_en = 0;

    // R11 add clears result bits
    wr_add(3'b001);
    check("R11 tx_done0 cleared", 32'(tx_done[0]), 0);
    check("R11 cxl_done0 cleared", 32'(cxl_done[0]), 0);
    check("R11 tx_done1 kept", 32'(tx_done[1]), 1);
    wait_n(10);

    // R8 cancel then arbitration lost
    eng(0, 0);
    wr_cxl(3'b001);
    wait_n(2);
    eng(2, 0);
    check("R8 pend0 cleared", 32'(pend[0]), 0);
    check("R8 cxl_done0", 32'(cxl_done[0]), 1);
    check("R8 no tx_done0", 32'(tx_done[0]), 0);
    wait_n(4);

    // R10 retry on error
    wr_add(3'b001);
    wait_n(10);
    eng(0, 0);
    eng(3, 0);
    check("R10 still pending", 32'(pend[0]), 1);
    check("R10 no cancel finish", 32'(cxl_done[0]), 0);
    wait_n(10);
    check("R10 reselected valid", 32'(sel_valid), 1);
    check("R10 reselected idx", 32'(sel_idx), 0);

    // R9 no-retransmit mode
    no_retx = 1;
    eng(0, 0);
    eng(2, 0);
    check("R9 pend0 cleared", 32'(pend[0]), 0);
    check("R9 cxl_done0", 32'(cxl_done[0]), 1);
    no_retx = 0;
    wait_n(10);

    // R5 cancel of idle pending buffer
    check("R5 buf2 pending", 32'(pend[2]), 1);
    wr_cxl(3'b100);
    check("R4 cxl_req2 set", 32'(cxl_req[2]), 1);
    @(negedge clk);
    check("R5 pend2 cleared", 32'(pend[2]), 0);
    check("R5 cxl_done2", 32'(cxl_done[2]), 1);
    wait_n(3);
    // R5 cancel of non-pending buffer
    wr_cxl(3'b010);
    check("R5 immediate finish", 32'(cxl_done[1]), 1);
    check("R4 no req for idle", 32'(cxl_req[1]), 0);
    wait_n(10);
    check("R3 nothing selected", 32'(sel_valid), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule